// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block is the front end of a bus-master DMA engine. Software fills a table of 8-byte region descriptors in memory, writes the table base address, and pulses a start strobe. The walker then reads the descriptors one at a time over a simple memory read port. It decodes each descriptor into an aligned region start address and a byte count. For each descriptor it raises one transfer request toward the data mover and holds it until the mover reports that the transfer is done.

Each descriptor carries a last-entry flag in its top bit. When the transfer for a flagged descriptor completes, the walker returns to idle. It raises a one-cycle done pulse and sets a sticky interrupt bit. Software can abandon a walk with a stop strobe. A base address that is not 8-byte aligned is refused and reported through an error bit. The data movement itself and the device-side protocol are handled elsewhere.

Top module: `sg_walker`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `mem_req`, `xfer_req`, `done`, `irq` and `align_err` are all 0.
- R2: The first descriptor read after a start uses the base register value. Each following read is at the previous read address plus 8.
- R3: `xfer_addr` equals descriptor bits [31:3] followed by three zero bits. Descriptor bits [2:0] never reach the address.
- R4: `xfer_len` equals descriptor bits [47:35] followed by three zero bits. The reserved descriptor bits [62:48] and [34:32] have no effect on any output.
- R5: A descriptor whose bits [47:35] are all zero yields `xfer_len` = 65536.
- R6: When descriptor bit 63 is 1, the walker goes idle once that region's `xfer_done` arrives and reads no further descriptors. On that clock, `done` pulses for exactly one cycle and `irq` sets. `irq` stays set until `irq_clr` is pulsed; a new completion in the same cycle takes precedence over the clear.
- R7: A start while idle with base bits [2:0] nonzero sets `align_err`, and `busy` stays 0 with no memory read. A start with an aligned base clears `align_err`.
- R8: Exactly one transfer request is issued per descriptor. `xfer_req` holds its address and length steady until `xfer_done`. `mem_req` and `xfer_req` are never high together.
- R9: `busy` is high from the clock after an accepted start until the walk ends.
- R10: A stop pulse during a walk takes effect at the next step. If a read is outstanding, the walker goes idle when that read returns and issues no request for it. If a transfer is pending, that transfer completes and no further descriptor is read. An aborted walk raises neither `done` nor `irq`.
- R11: `mem_req` stays high with a stable `mem_addr` for any number of cycles until `mem_rvalid`.
- R12: A start pulse while `busy` is high is ignored; the walk in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_we | input | 1 | Write strobe for the table base register |
| base_wdata | input | 32 | Table base address to write |
| start | input | 1 | Start pulse |
| stop | input | 1 | Abort pulse |
| irq_clr | input | 1 | Clears the sticky interrupt |
| mem_req | output | 1 | Descriptor read request, held until valid |
| mem_addr | output | 32 | Descriptor read address |
| mem_rvalid | input | 1 | Read data valid (one cycle) |
| mem_rdata | input | 64 | Descriptor read data |
| xfer_req | output | 1 | Region transfer request, held until done |
| xfer_addr | output | 32 | Region start address |
| xfer_len | output | 17 | Region length in bytes |
| xfer_done | input | 1 | Transfer-done pulse |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-table pulse |
| irq | output | 1 | Sticky end-of-table interrupt |
| align_err | output | 1 | Misaligned base refused |

## Verification
Several properties are checked on every cycle by the assertions. The read address and the pending transfer are held steady across wait cycles, and the two request outputs never overlap. Each next read steps by 8, every issued length is a nonzero multiple of 8, and a refused or aborted start leaves the walker idle. The done pulse always comes with the interrupt. Other behaviours can only be shown by the bench's scenarios: the decoded values from descriptors with reserved bits set, the end of a walk at the flagged entry, the 65536 length, the two stop cases, and a start ignored while busy. The bench checks these against its reference model and its transfer log.

// File: rtl/sgw_pkg.sv
// sgw_pkg: shared constants and types for the descriptor table walker.
// Assumes a fixed 64-bit descriptor with the field positions below.
package sgw_pkg;
    localparam int ADDR_W  = 32;
    localparam int DESC_W  = 64;
    localparam int ALIGN_B = 3;
    localparam int CNT_LO  = 35;
    localparam int CNT_HI  = 47;
    localparam int CNT_W   = CNT_HI - CNT_LO + 1;
    localparam int LEN_W   = CNT_W + ALIGN_B + 1;
    localparam int EOT_POS = 63;
    localparam int STRIDE  = 1 << ALIGN_B;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER} walk_st_t;

    typedef struct packed {
        logic              last;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } region_t;
endpackage

// File: rtl/sgw_decode.sv
// sgw_decode: combinational decode of one descriptor into a region.
// Assumes reserved bits carry no meaning; a zero count means the largest size.
module sgw_decode
    import sgw_pkg::*;
(
    input  logic [DESC_W-1:0] desc_i,
    output region_t           region_o
);
    logic [CNT_W-1:0] cnt;

    // Pull out the count field and build the aligned address, length and last flag.
    always_comb begin
        cnt             = desc_i[CNT_HI:CNT_LO];
        region_o.last   = desc_i[EOT_POS];
        region_o.addr   = {desc_i[ADDR_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
        region_o.len    = (cnt == '0) ? {1'b1, {(LEN_W-1){1'b0}}}
                                      : {1'b0, cnt, {ALIGN_B{1'b0}}};
    end
endmodule

// File: rtl/sgw_seq.sv
// sgw_seq: walk state machine. It reads one descriptor, issues one transfer,
// waits for completion, then moves to the next entry or stops.
// Assumes mem_rvalid and xfer_done are single-cycle pulses answering a held request.
module sgw_seq
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              mem_rvalid_i,
    input  region_t           region_i,
    input  logic              xfer_done_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              xfer_req_o,
    output logic [ADDR_W-1:0] xfer_addr_o,
    output logic [LEN_W-1:0]  xfer_len_o,
    output logic              busy_o,
    output logic              start_ok_o,
    output logic              start_bad_o,
    output logic              table_end_o
);
    walk_st_t          state;
    logic [ADDR_W-1:0] ptr;
    logic              stop_q;
    region_t           cur;
    logic              abort;
    logic              base_ok;

    // Abort request seen now or earlier in this walk; base alignment test.
    always_comb begin
        abort   = stop_q | stop_i;
        base_ok = (base_i[ALIGN_B-1:0] == '0);
    end

    // State, read pointer, pending stop and latched region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            stop_q <= 1'b0;
            cur    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i && base_ok) begin
                        ptr    <= base_i;
                        stop_q <= 1'b0;
                        state  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (stop_i) stop_q <= 1'b1;
                    if (mem_rvalid_i) begin
                        if (abort) begin
                            stop_q <= 1'b0;
                            state  <= ST_IDLE;
                        end else begin
                            cur   <= region_i;
                            state <= ST_XFER;
                        end
                    end
                end
                ST_XFER: begin
                    if (stop_i) stop_q <= 1'b1;
                    if (xfer_done_i) begin
                        if (cur.last || abort) begin
                            stop_q <= 1'b0;
                            state  <= ST_IDLE;
                        end else begin
                            ptr   <= ptr + ADDR_W'(STRIDE);
                            state <= ST_FETCH;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the handshakes and the start/end events from the state.
    always_comb begin
        mem_req_o   = (state == ST_FETCH);
        mem_addr_o  = ptr;
        xfer_req_o  = (state == ST_XFER);
        xfer_addr_o = cur.addr;
        xfer_len_o  = cur.len;
        busy_o      = (state != ST_IDLE);
        start_ok_o  = (state == ST_IDLE) && start_i && base_ok;
        start_bad_o = (state == ST_IDLE) && start_i && !base_ok;
        table_end_o = (state == ST_XFER) && xfer_done_i && cur.last;
    end

    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
    p_one_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && xfer_req_o));
    p_xfer_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && !xfer_done_i) |=> (xfer_req_o && $stable(xfer_addr_o) && $stable(xfer_len_o)));
    p_stride_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && xfer_done_i && !cur.last && !abort)
        |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(STRIDE)));
    p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> (xfer_len_o != '0 && xfer_len_o[ALIGN_B-1:0] == '0));
    p_bad_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_bad_o |=> !busy_o);
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_rvalid_i && abort) |=> (!busy_o && !xfer_req_o));
endmodule

// File: rtl/sgw_status.sv
// sgw_status: completion pulse, sticky interrupt and alignment error bit.
// Assumes start_ok and start_bad are never high together.
module sgw_status (
    input  logic clk,
    input  logic rst_n,
    input  logic start_ok_i,
    input  logic start_bad_i,
    input  logic table_end_i,
    input  logic irq_clr_i,
    output logic done_o,
    output logic irq_o,
    output logic align_err_o
);
    // Registers the status bits; a completion beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            irq_o       <= 1'b0;
            align_err_o <= 1'b0;
        end else begin
            done_o <= table_end_i;
            if (table_end_i)    irq_o <= 1'b1;
            else if (irq_clr_i) irq_o <= 1'b0;
            if (start_bad_i)     align_err_o <= 1'b1;
            else if (start_ok_i) align_err_o <= 1'b0;
        end
    end

    p_done_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> irq_o);
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_align_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_bad_i |=> align_err_o);
endmodule

// File: rtl/sg_walker.sv
// sg_walker: top of the descriptor table walker. It holds the base register
// and connects the decoder, the sequencer and the status block.
// Assumes software prepares the table before pulsing start.
module sg_walker
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              start,
    input  logic              stop,
    input  logic              irq_clr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DESC_W-1:0] mem_rdata,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_done,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic              align_err
);
    logic [ADDR_W-1:0] base_q;
    region_t           region;
    logic              start_ok, start_bad, table_end;

    // Software-written table base register.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_we) base_q <= base_wdata;
    end

    sgw_decode u_dec (
        .desc_i   (mem_rdata),
        .region_o (region)
    );

    sgw_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .stop_i       (stop),
        .base_i       (base_q),
        .mem_rvalid_i (mem_rvalid),
        .region_i     (region),
        .xfer_done_i  (xfer_done),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .xfer_req_o   (xfer_req),
        .xfer_addr_o  (xfer_addr),
        .xfer_len_o   (xfer_len),
        .busy_o       (busy),
        .start_ok_o   (start_ok),
        .start_bad_o  (start_bad),
        .table_end_o  (table_end)
    );

    sgw_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_ok_i  (start_ok),
        .start_bad_i (start_bad),
        .table_end_i (table_end),
        .irq_clr_i   (irq_clr),
        .done_o      (done),
        .irq_o       (irq),
        .align_err_o (align_err)
    );

    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> busy);
endmodule

// File: tb/sg_walker_bench.sv
// sg_walker_bench: reference model compared every cycle plus scenario checks.
module sg_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        start = 1'b0, stop = 1'b0, irq_clr = 1'b0;
    logic        mem_req, xfer_req, busy, done, irq, align_err;
    logic [31:0] mem_addr, xfer_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic [16:0] xfer_len;
    logic        xfer_done = 1'b0;

    always #2 clk = ~clk;

    sg_walker u_sg_walker (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
        .start(start), .stop(stop), .irq_clr(irq_clr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_done(xfer_done),
        .busy(busy), .done(done), .irq(irq), .align_err(align_err)
    );

    int tests = 0, fails = 0, cycles = 0;
    logic comparing = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory holding the table and the transfer responder settings.
    logic [63:0] tbl [0:7];
    logic [31:0] tbl_base = 32'h1000;
    int mem_wait = 0, ack_wait = 0, mcnt = 0, acnt = 0;
    logic [31:0] log_a [0:63];
    logic [16:0] log_l [0:63];
    int xcnt = 0;
    logic xreq_d = 1'b0;

    function automatic logic [63:0] mk(input logic [31:0] a, input logic [12:0] c, input logic last);
        return {last, 15'h5a5a, c, 3'b101, a[31:3], 3'b111};
    endfunction

    // Behavioural reference model, advanced on each rising edge.
    int          m_st = 0;
    logic [31:0] m_ptr = 0, m_base = 0, m_xa = 0;
    logic [16:0] m_xl = 0;
    logic        m_stop = 0, m_eot = 0, m_done = 0, m_irq = 0, m_align = 0;
    always @(posedge clk) begin
        logic ab, set_irq;
        if (!rst_n) begin
            m_st = 0; m_ptr = 0; m_base = 0; m_xa = 0; m_xl = 0;
            m_stop = 0; m_eot = 0; m_done = 0; m_irq = 0; m_align = 0;
        end else begin
            ab = m_stop || stop;
            set_irq = 0;
            m_done = 0;
            if (m_st == 0) begin
                if (start) begin
                    if (m_base[2:0] != 0) m_align = 1;
                    else begin m_align = 0; m_ptr = m_base; m_stop = 0; m_st = 1; end
                end
            end else if (m_st == 1) begin
                if (mem_rvalid) begin
                    if (ab) begin m_st = 0; m_stop = 0; end
                    else begin
                        m_xa = {mem_rdata[31:3], 3'b000};
                        m_xl = (mem_rdata[47:35] == 0) ? 17'd65536 : 17'(mem_rdata[47:35]) * 17'd8;
                        m_eot = mem_rdata[63];
                        m_st = 2;
                    end
                end else if (stop) m_stop = 1;
            end else begin
                if (xfer_done) begin
                    if (m_eot) begin m_st = 0; m_done = 1; set_irq = 1; m_stop = 0; end
                    else if (ab) begin m_st = 0; m_stop = 0; end
                    else begin m_ptr = m_ptr + 8; m_st = 1; end
                end else if (stop) m_stop = 1;
            end
            if (set_irq) m_irq = 1;
            else if (irq_clr) m_irq = 0;
            if (base_we) m_base = base_wdata;
        end
    end

    // Falling edge: compare outputs, log transfers, then drive responders.
    always @(negedge clk) begin
        cycles++;
        if (comparing) begin
            chk("R9", "busy", 32'(busy), 32'(m_st != 0));
            chk("R8", "mem_req", 32'(mem_req), 32'(m_st == 1));
            if (mem_req) chk("R2", "mem_addr", mem_addr, m_ptr);
            chk("R8", "xfer_req", 32'(xfer_req), 32'(m_st == 2));
            if (xfer_req) begin
                chk("R3", "xfer_addr", xfer_addr, m_xa);
                chk("R4", "xfer_len", 32'(xfer_len), 32'(m_xl));
            end
            chk("R6", "done", 32'(done), 32'(m_done));
            chk("R6", "irq", 32'(irq), 32'(m_irq));
            chk("R7", "align_err", 32'(align_err), 32'(m_align));
        end
        if (xfer_req && !xreq_d && xcnt < 64) begin
            log_a[xcnt] = xfer_addr; log_l[xcnt] = xfer_len; xcnt++;
        end
        xreq_d = xfer_req;
        if (mem_rvalid) begin mem_rvalid = 0; mcnt = 0; end
        else if (mem_req) begin
            if (mcnt >= mem_wait) begin
                int idx;
                idx = int'((mem_addr - tbl_base) >> 3);
                mem_rvalid = 1;
                mem_rdata = (idx >= 0 && idx < 8) ? tbl[idx] : 64'h8000_0000_0000_0000;
            end else mcnt++;
        end
        if (xfer_done) begin xfer_done = 0; acnt = 0; end
        else if (xfer_req) begin
            if (acnt >= ack_wait) xfer_done = 1;
            else acnt++;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1; @(negedge clk); start = 0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); stop = 1; @(negedge clk); stop = 0;
    endtask
    task automatic set_base(input logic [31:0] v);
        @(negedge clk); base_we = 1; base_wdata = v; @(negedge clk); base_we = 0;
    endtask
    task automatic wait_idle();
        for (int i = 0; i < 500 && busy; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        comparing = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset outputs", {26'd0, busy, mem_req, xfer_req, done, irq, align_err}, 32'd0);

        // R2 R3 R4 R6: three-entry table, reserved bits set
        tbl[0] = mk(32'h2000_0008, 13'd4, 1'b0);
        tbl[1] = mk(32'h3000_0100, 13'h1fff, 1'b0);
        tbl[2] = mk(32'h4000_0040, 13'd1, 1'b1);
        set_base(32'h1000);
        pulse_start();
        wait_idle();
        chk("R6", "regions before end", xcnt, 3);
        chk("R3", "region0 addr", log_a[0], 32'h2000_0008);
        chk("R4", "region1 len", 32'(log_l[1]), 32'hfff8);
        chk("R4", "region2 len", 32'(log_l[2]), 32'd8);
        chk("R6", "irq after end", 32'(irq), 1);
        @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
        @(negedge clk);
        chk("R6", "irq cleared", 32'(irq), 0);

        // R5 R11: zero count with wait states
        tbl[0] = mk(32'h5000_0000, 13'd0, 1'b1);
        mem_wait = 5; ack_wait = 3;
        pulse_start();
        wait_idle();
        chk("R5", "zero count length", 32'(log_l[3]), 32'd65536);
        chk("R11", "one region after waits", xcnt, 4);

        // R7: misaligned base refused, then aligned start clears
        set_base(32'h1004);
        pulse_start();
        repeat (3) @(negedge clk);
        chk("R7", "align_err set", 32'(align_err), 1);
        chk("R7", "no walk", 32'(busy), 0);
        set_base(32'h1000);
        pulse_start();
        wait_idle();
        chk("R7", "align_err cleared", 32'(align_err), 0);
        @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;

        // R10: stop while a read is outstanding
        tbl[0] = mk(32'h2000_0008, 13'd4, 1'b0);
        mem_wait = 8; ack_wait = 0;
        pulse_start();
        repeat (2) @(negedge clk);
        pulse_stop();
        wait_idle();
        chk("R10", "no request after stop", xcnt, 5);
        chk("R10", "no irq on abort", 32'(irq), 0);

        // R10: stop while a transfer is pending
        mem_wait = 0; ack_wait = 6;
        pulse_start();
        for (int i = 0; i < 100 && !xfer_req; i++) @(negedge clk);
        pulse_stop();
        wait_idle();
        chk("R10", "pending transfer finishes alone", xcnt, 6);

        // R12: start while busy ignored
        mem_wait = 2; ack_wait = 1;
        pulse_start();
        set_base(32'h1008);
        pulse_start();
        wait_idle();
        chk("R12", "full walk kept", xcnt, 9);
        chk("R12", "walk began at old base", log_a[6], 32'h2000_0008);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule